// File: doc/BRIEF.md
# UART Receive Error Status Controller

This block keeps the receive error flags of a UART-style serial receiver and derives one error interrupt request from them. A receiver datapath hands it, once per character, the three mid-bit samples of the start bit, every data bit, the parity bit and the stop bit, together with a character-complete strobe. The block votes each bit by majority and holds the voted data word. It sets sticky noise, framing and parity flags.

Software clears a flag in two steps: it reads the status register while the flag is set, then reads the receive data register. A debug-break input and a break-clear-enable control bit decide whether accesses made while the chip is halted for debug may clear flags. The bit resets to protect the flags. A stop-mode input freezes all state. In the wait state no input changes, so the block keeps running and its interrupt stays live.

Top module: `rxErrStatus`

## Requirements
- R1: On a character strobe the noise flag is set when any bit has three samples that are not all equal. This covers the start bit, every data bit, the stop bit, and the parity bit when parity is enabled.
- R2: On a character strobe the data output loads the majority value of each data bit's three samples. Bit i of the word comes from samples 3i+2..3i of the data sample bus.
- R3: On a character strobe the framing flag is set when the majority value of the stop bit is 0.
- R4: With parity enabled, the parity flag is set when the voted parity bit differs from the XOR of the voted data bits, inverted when odd parity is selected. With parity disabled, the parity bit and its samples have no effect on the flags.
- R5: The error request equals the OR of each flag ANDed with its enable. The control write data assigns bit 0 to the noise enable, bit 1 to the framing enable and bit 2 to the parity enable. The request is asserted in the same cycle that a flag or an enable becomes visible.
- R6: A receive-data read clears only those flags that were 1 at the last status read. A data read with no prior status read clears nothing. The armed set is emptied by the data read.
- R7: Control write data bit 3 is the break-clear-enable bit, and it resets to 0. While it is 0 and the debug-break input is high, status and data reads change no flag.
- R8: A status read made during a protected break arms nothing, so a data read after the break ends leaves the flags set.
- R9: While break-clear-enable is 1, the two-step clear works during debug break, and the cleared flag stays 0 after the break ends.
- R10: While stop mode is high, character strobes, reads and control writes are ignored, and every flag, the data word and the control bits keep their values. Operation resumes when stop mode falls.
- R11: An error event in the same cycle as a clearing data read leaves its flag set.
- R12: After reset all flags, the data word and the error request are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stopMode | input | 1 | Freeze request from the low-power controller |
| dbgBreak | input | 1 | Chip halted for debug |
| charDone | input | 1 | One-cycle strobe: samples of a complete character are valid |
| startSamp | input | 3 | Three mid-bit samples of the start bit |
| dataSamp | input | 3*DATA_W | Three samples per data bit, bit i in [3i+2:3i] |
| parSamp | input | 3 | Three samples of the parity bit |
| stopSamp | input | 3 | Three samples of the stop bit |
| parEn | input | 1 | A parity bit is present in the frame |
| parOdd | input | 1 | Odd parity selected |
| stsRead | input | 1 | Software read of the status register |
| dataRead | input | 1 | Software read of the receive data register |
| ctlWe | input | 1 | Control register write strobe |
| ctlWdata | input | 4 | Control write data: enables in bits 2..0, break-clear-enable in bit 3 |
| noiseFlag | output | 1 | Noise flag |
| frameFlag | output | 1 | Framing error flag |
| parFlag | output | 1 | Parity error flag |
| rxData | output | DATA_W | Majority-voted received word |
| errIrq | output | 1 | Error interrupt request |

## Verification
An armed mask that is lost or kept too long shows up only at the data read that follows. That read clears either too little or too much, and the flag output shows it one cycle after that read. Gating that treats break or stop mode wrongly shows up as a flag falling in the cycle after a read that should have had no effect. A wrong enable mapping shows on the error request in the same cycle as the control write takes effect. Each check therefore samples the outputs one edge after the stimulus, so a divergence is reported at the first access that exposes it.

// File: rtl/rxErrPkg.sv
package rxErrPkg;

  localparam int FLAG_N = 3;
  localparam int NZ_IDX = 0;
  localparam int FE_IDX = 1;
  localparam int PE_IDX = 2;

  typedef struct packed {
    logic capture;
    logic arm;
    logic clear;
  } rxErrStb_t;

  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  function automatic logic split3(input logic [2:0] s);
    return (s != 3'b000) && (s != 3'b111);
  endfunction

endpackage

// File: rtl/rxErrControl.sv
module rxErrControl
  import rxErrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopMode,
  input  logic              dbgBreak,
  input  logic              charDone,
  input  logic              stsRead,
  input  logic              dataRead,
  input  logic              ctlWe,
  input  logic [3:0]        ctlWdata,
  output rxErrStb_t         stb,
  output logic [FLAG_N-1:0] irqEn,
  output logic              bce
);

  logic accessOk;

  // software accesses may touch status unless frozen or protected by break
  assign accessOk    = !stopMode && (!dbgBreak || bce);
  assign stb.capture = !stopMode && charDone;
  assign stb.arm     = accessOk && stsRead;
  assign stb.clear   = accessOk && dataRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn <= '0;
      bce   <= 1'b0;
    end else if (!stopMode && ctlWe) begin
      irqEn <= ctlWdata[FLAG_N-1:0];
      bce   <= ctlWdata[3];
    end
  end

endmodule

// File: rtl/rxErrDatapath.sv
module rxErrDatapath
  import rxErrPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  rxErrStb_t           stb,
  input  logic [2:0]          startSamp,
  input  logic [3*DATA_W-1:0] dataSamp,
  input  logic [2:0]          parSamp,
  input  logic [2:0]          stopSamp,
  input  logic                parEn,
  input  logic                parOdd,
  input  logic [FLAG_N-1:0]   irqEn,
  output logic [FLAG_N-1:0]   flags,
  output logic [DATA_W-1:0]   rxData,
  output logic                errIrq
);

  logic [DATA_W-1:0] dataVote;
  logic [DATA_W-1:0] dataSplit;
  logic              parVote;
  logic              expPar;
  logic [FLAG_N-1:0] evt;
  logic [FLAG_N-1:0] armQ;
  logic [FLAG_N-1:0] clrMask;
  logic [FLAG_N-1:0] setMask;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_bit
      assign dataVote[gi]  = vote3(dataSamp[3*gi +: 3]);
      assign dataSplit[gi] = split3(dataSamp[3*gi +: 3]);
    end
  endgenerate

  assign parVote = vote3(parSamp);
  assign expPar  = (^dataVote) ^ parOdd;

  assign evt[NZ_IDX] = split3(startSamp) || (|dataSplit) || split3(stopSamp) ||
                       (parEn && split3(parSamp));
  assign evt[FE_IDX] = !vote3(stopSamp);
  assign evt[PE_IDX] = parEn && (parVote != expPar);

  assign clrMask = stb.clear   ? armQ : '0;
  assign setMask = stb.capture ? evt  : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags  <= '0;
      armQ   <= '0;
      rxData <= '0;
    end else begin
      // a new event wins over a clear in the same cycle
      flags <= (flags & ~clrMask) | setMask;
      if (stb.arm)        armQ <= flags;
      else if (stb.clear) armQ <= '0;
      if (stb.capture)    rxData <= dataVote;
    end
  end

  assign errIrq = |(flags & irqEn);

endmodule

// File: rtl/rxErrStatus.sv
module rxErrStatus
  import rxErrPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                stopMode,
  input  logic                dbgBreak,
  input  logic                charDone,
  input  logic [2:0]          startSamp,
  input  logic [3*DATA_W-1:0] dataSamp,
  input  logic [2:0]          parSamp,
  input  logic [2:0]          stopSamp,
  input  logic                parEn,
  input  logic                parOdd,
  input  logic                stsRead,
  input  logic                dataRead,
  input  logic                ctlWe,
  input  logic [3:0]          ctlWdata,
  output logic                noiseFlag,
  output logic                frameFlag,
  output logic                parFlag,
  output logic [DATA_W-1:0]   rxData,
  output logic                errIrq
);

  rxErrStb_t         stb;
  logic [FLAG_N-1:0] ctlIrqEn;
  logic              ctlBce;
  logic [FLAG_N-1:0] flagVec;

  rxErrControl u_ctl (
    .clk(clk), .rstN(rstN), .stopMode(stopMode), .dbgBreak(dbgBreak),
    .charDone(charDone), .stsRead(stsRead), .dataRead(dataRead),
    .ctlWe(ctlWe), .ctlWdata(ctlWdata), .stb(stb), .irqEn(ctlIrqEn), .bce(ctlBce)
  );

  rxErrDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .startSamp(startSamp), .dataSamp(dataSamp),
    .parSamp(parSamp), .stopSamp(stopSamp), .parEn(parEn), .parOdd(parOdd),
    .irqEn(ctlIrqEn), .flags(flagVec), .rxData(rxData), .errIrq(errIrq)
  );

  assign noiseFlag = flagVec[NZ_IDX];
  assign frameFlag = flagVec[FE_IDX];
  assign parFlag   = flagVec[PE_IDX];

endmodule

// File: rtl/rxErrChecker.sv
module rxErrChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopMode,
  input logic              dbgBreak,
  input logic              dataRead,
  input logic              bce,
  input logic [2:0]        irqEn,
  input logic [2:0]        flags,
  input logic [DATA_W-1:0] rxData,
  input logic              errIrq
);

  AST_IRQ_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (flags == 3'b000) |-> !errIrq); // R5

  AST_IRQ_IDLE_EN: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn == 3'b000) |-> !errIrq); // R5

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    stopMode |=> ($stable(flags) && $stable(rxData) && $stable(bce))); // R10

  AST_BREAK_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (dbgBreak && !bce) |=> ((flags & $past(flags)) == $past(flags))); // R7

  AST_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(flags) & ~flags)) |-> $past(dataRead)); // R6

  AST_BCE_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !bce); // R7

endmodule

bind rxErrStatus rxErrChecker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .stopMode(stopMode), .dbgBreak(dbgBreak),
  .dataRead(dataRead), .bce(ctlBce), .irqEn(ctlIrqEn), .flags(flagVec),
  .rxData(rxData), .errIrq(errIrq)
);

// File: tb/test_rxErrStatus.sv
module test_rxErrStatus;

  localparam int DW = 8;

  typedef struct {
    logic [2:0]    f;
    logic          irq;
    logic [DW-1:0] d;
    string         tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopMode = 0, dbgBreak = 0, charDone = 0, parEn = 0, parOdd = 0;
  logic stsRead = 0, dataRead = 0, ctlWe = 0;
  logic [3:0] ctlWdata = '0;
  logic [2:0] startSamp = '0, parSamp = '0, stopSamp = 3'b111;
  logic [3*DW-1:0] dataSamp = '0;
  logic noiseFlag, frameFlag, parFlag, errIrq;
  logic [DW-1:0] rxData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  expItem_t expQ[$];

  // bench model
  logic [2:0]    mF = '0, mArm = '0, mIe = '0;
  logic          mBce = 0;
  logic [DW-1:0] mD = '0;
  logic [2:0]    evF = '0;
  logic [DW-1:0] evD = '0;

  always #10 clk = ~clk;

  rxErrStatus #(.DATA_W(DW)) i_rxErrStatus (
    .clk(clk), .rstN(rstN), .stopMode(stopMode), .dbgBreak(dbgBreak),
    .charDone(charDone), .startSamp(startSamp), .dataSamp(dataSamp),
    .parSamp(parSamp), .stopSamp(stopSamp), .parEn(parEn), .parOdd(parOdd),
    .stsRead(stsRead), .dataRead(dataRead), .ctlWe(ctlWe), .ctlWdata(ctlWdata),
    .noiseFlag(noiseFlag), .frameFlag(frameFlag), .parFlag(parFlag),
    .rxData(rxData), .errIrq(errIrq)
  );

  // monitor
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      logic [2:0] act;
      e = expQ.pop_front();
      act = {parFlag, frameFlag, noiseFlag};
      checks++;
      if (act !== e.f || errIrq !== e.irq || rxData !== e.d) begin
        errors++;
        $display("FAIL %s: flags/irq/data act=%b/%b/%h exp=%b/%b/%h",
                 e.tag, act, errIrq, rxData, e.f, e.irq, e.d);
      end
    end
  end

  task automatic push(string tag);
    expItem_t e;
    e.f = mF; e.irq = |(mF & mIe); e.d = mD; e.tag = tag;
    expQ.push_back(e);
  endtask

  // one clock with the current inputs; model updates alongside
  task automatic step(string tag);
    logic eff;
    logic [2:0] nF, nArm;
    eff  = !stopMode && (!dbgBreak || mBce);
    nF   = mF;
    nArm = mArm;
    if (eff && dataRead) begin nF = nF & ~mArm; nArm = '0; end
    if (eff && stsRead) nArm = mF;
    if (!stopMode && charDone) begin nF = nF | evF; mD = evD; end
    if (!stopMode && ctlWe) begin mIe = ctlWdata[2:0]; mBce = ctlWdata[3]; end
    @(posedge clk); #1;
    mF = nF; mArm = nArm;
    push(tag);
    charDone = 0; stsRead = 0; dataRead = 0; ctlWe = 0;
  endtask

  // noisyIdx: -1 none, 0 start, 1..DW data, DW+1 parity, DW+2 stop
  task automatic putChar(input logic [DW-1:0] d, input int noisyIdx, input logic stopVal,
                         input logic flipPar, input logic pe, input logic po);
    logic pbit;
    pbit = (^d) ^ po ^ flipPar;
    startSamp = 3'b000;
    for (int i = 0; i < DW; i++) dataSamp[3*i +: 3] = {3{d[i]}};
    parSamp  = {3{pbit}};
    stopSamp = {3{stopVal}};
    if (noisyIdx == 0) startSamp[1] = 1'b1;
    if (noisyIdx >= 1 && noisyIdx <= DW) dataSamp[3*(noisyIdx-1)+1] = ~d[noisyIdx-1];
    if (noisyIdx == DW+1) parSamp[0] = ~pbit;
    if (noisyIdx == DW+2) stopSamp[2] = ~stopVal;
    parEn = pe; parOdd = po; charDone = 1;
    evD = d;
    evF[0] = (noisyIdx >= 0) && !(noisyIdx == DW+1 && !pe);
    evF[1] = !stopVal;
    evF[2] = pe && flipPar;
  endtask

  task automatic clearSeq(string tag);
    stsRead = 1;  step({tag, " status read"});
    dataRead = 1; step({tag, " data read"});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    push("R12 reset state");
    @(posedge clk); #1;

    putChar(8'hA5, -1, 1, 0, 1, 0); step("R2 clean char data");
    putChar(8'h3C, 0, 1, 0, 0, 0);  step("R1 noise on start bit");
    clearSeq("R6 clear noise");
    putChar(8'h96, 4, 1, 0, 0, 0);  step("R1 R2 noise on data bit keeps vote");
    clearSeq("R6 clear");
    putChar(8'h11, DW+2, 1, 0, 0, 0); step("R1 noise on stop bit");
    clearSeq("R6 clear");
    putChar(8'h55, DW+1, 1, 0, 0, 0); step("R4 parity samples ignored when disabled");
    putChar(8'h55, DW+1, 1, 0, 1, 0); step("R1 noise on parity bit");
    clearSeq("R6 clear");
    putChar(8'h00, -1, 0, 0, 0, 0); step("R3 framing on zero stop");
    putChar(8'h7E, -1, 1, 1, 1, 0); step("R4 even parity mismatch");
    clearSeq("R6 clear frame and parity");
    putChar(8'h7E, -1, 1, 0, 1, 1); step("R4 odd parity match");
    putChar(8'h7E, -1, 1, 1, 1, 1); step("R4 odd parity mismatch");
    putChar(8'h7E, -1, 1, 1, 0, 1); step("R4 wrong parity ignored when disabled");

    ctlWdata = 4'b0001; ctlWe = 1; step("R5 noise enable only, parity flag set");
    ctlWdata = 4'b0100; ctlWe = 1; step("R5 parity enable raises request");
    dataRead = 1; step("R6 data read without status read keeps flag");
    clearSeq("R6 clear parity");
    putChar(8'h42, -1, 0, 0, 0, 0); step("R5 frame set, enable off");
    ctlWdata = 4'b0010; ctlWe = 1; step("R5 frame enable raises request");
    putChar(8'h42, 2, 1, 0, 0, 0); step("R6 noise set after frame");
    stsRead = 1; step("R6 arm both");
    putChar(8'h43, -1, 1, 1, 1, 0); step("R6 parity set after arm");
    dataRead = 1; step("R6 only armed flags clear");
    clearSeq("R6 clear parity last");

    putChar(8'h18, -1, 0, 0, 0, 0); step("R3 frame again");
    dbgBreak = 1;
    stsRead = 1; step("R7 protected status read");
    dataRead = 1; step("R7 protected data read keeps flag");
    dbgBreak = 0; step("R8 break ends");
    dataRead = 1; step("R8 no arm from protected read");

    ctlWdata = 4'b1010; ctlWe = 1; step("R9 enable break clearing");
    dbgBreak = 1;
    clearSeq("R9 clear in break");
    dbgBreak = 0; step("R9 stays cleared after break");

    putChar(8'h24, -1, 0, 0, 0, 0); step("R3 frame for stop test");
    stsRead = 1; step("R10 arm before stop");
    stopMode = 1;
    putChar(8'hFF, 3, 1, 1, 1, 0); step("R10 char ignored in stop");
    dataRead = 1; step("R10 read ignored in stop");
    ctlWdata = 4'b0000; ctlWe = 1; step("R10 control write ignored in stop");
    stopMode = 0; step("R10 resume");
    dataRead = 1; step("R10 armed clear after resume");

    putChar(8'h81, -1, 0, 0, 0, 0); step("R11 frame set");
    stsRead = 1; step("R11 arm");
    putChar(8'h82, -1, 0, 0, 0, 0); dataRead = 1; step("R11 set wins over clear");
    clearSeq("R11 clear afterwards");

    repeat (2) @(posedge clk);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule